// File: doc/BRIEF.md
# Status Register Write Protection Unit

This unit sits inside a serial memory slave. It holds the 8-bit status register and the volatile write-enable latch, and it tells the rest of the slave whether a byte write to the array or a write to the status register may go ahead. The command decoder drives it with single-cycle strobes: one strobe sets the latch, one clears it, and one writes the status register with a data byte. The unit also receives the address of the pending array write and a write-protect pin that has already been synchronized.

Its outputs are the status byte for readback, an array write-permit flag for the presented address, and a status write-permit flag. Three things decide each permit. The first is the latch, which commands set and clear. The second is a lock bit in the status register, and the pin gates that lock. The third is a two-bit block-protect field that selects nothing, the top quarter, the top half, or all of the address space. The status bits are ordinary registers that reset to zero.

Top module: `prot_status_unit`

## Requirements
- R1: After reset the status byte reads 00h, and both permit flags are 0 for every address.
- R2: A set-latch strobe makes status bit 1 read 1 on the following cycle, and a clear-latch strobe makes it read 0. If both strobes arrive in the same cycle, the clear wins.
- R3: While status bit 1 is 0, the array permit and the status permit are both 0, and a status write strobe leaves the status byte unchanged.
- R4: Status bits 3:2 select the protected range of the 15-bit address. 00 protects nothing. 01 protects 6000h to 7FFFh. 10 protects 4000h to 7FFFh. 11 protects every address. With the latch at 1, the array permit is 1 exactly for the unprotected addresses.
- R5: An accepted status write loads bits 7:2 and bit 0 from the data byte. The result reads back on the next cycle.
- R6: While status bit 7 (the lock) is 1, a status write is accepted only if the pin is high, and a high pin also lets the write clear the lock. While the lock is 1 and the pin is low, the status permit is 0.
- R7: A refused status write leaves every status bit unchanged.
- R8: Status bit 1 is not taken from the data byte of a status write. Neither status writes nor changes of the write address alter it. Only the two latch strobes and reset do.
- R9: Bits 6:4 and bit 0 store and read back what was written, and they have no effect on either permit flag.
- R10: The pin is sampled in the cycle of the status write strobe. A pin change in the following cycle does not affect that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| setEnStb | input | 1 | One-cycle strobe that sets the write-enable latch |
| clrEnStb | input | 1 | One-cycle strobe that clears the write-enable latch |
| statWrStb | input | 1 | One-cycle strobe that writes the status register |
| statWrData | input | 8 | Data byte for a status write |
| wrAddr | input | 15 | Address of the pending array write |
| wpPin | input | 1 | Synchronized write-protect pin, high allows a locked status write |
| statusByte | output | 8 | Current status register value |
| memWrOk | output | 1 | Array write permitted at wrAddr |
| statWrOk | output | 1 | Status write permitted now |

## Verification
Each of the four block-protect codes is applied while the address walks across both edges of each quarter (0000h, 3FFFh, 4000h, 5FFFh, 6000h, 7FFFh). This separates a quarter decode from a half decode, and an off-by-one boundary from a correct one. Status writes are issued under each combination of latch, lock and pin. The data bytes have bit 1 clear and the user bits set, which shows whether the latch or the protection logic wrongly follows the data. In a further pattern the pin changes in the cycle right after the strobe, which shows whether the pin is sampled at the strobe or later.

// File: rtl/swg_pkg.sv
package swg_pkg;
  localparam int STAT_W  = 8;
  localparam int LOCK_BIT = 7;
  localparam int BP_HI   = 3;
  localparam int BP_LO   = 2;
  localparam int WEL_BIT = 1;

  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic loadStat;
  } swgCtlT;

  typedef enum logic [1:0] {
    PROT_NONE    = 2'b00,
    PROT_QUARTER = 2'b01,
    PROT_HALF    = 2'b10,
    PROT_ALL     = 2'b11
  } protSelT;
endpackage

// File: rtl/swg_ctrl.sv
module swg_ctrl
  import swg_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   setEnStb,
  input  logic   clrEnStb,
  input  logic   statWrStb,
  input  logic   wpPin,
  input  logic   welIn,
  input  logic   lockIn,
  output swgCtlT ctl,
  output logic   statWrOk
);
  // Permission for a status write: latch set, and lock either open or overridden by the pin.
  always_comb begin
    statWrOk     = welIn && (!lockIn || wpPin);
    ctl.clrWel   = clrEnStb;
    ctl.setWel   = setEnStb && !clrEnStb;   // clear has priority
    ctl.loadStat = statWrStb && statWrOk;   // pin taken at strobe cycle
  end

  // R3: no latch, no status permit
  assert_wel_gate_R3: assert property (@(posedge clk) disable iff (!rstN)
    !welIn |-> (!statWrOk && !ctl.loadStat));

  // R6: locked register with low pin never loads
  assert_lock_pin_R6: assert property (@(posedge clk) disable iff (!rstN)
    (lockIn && !wpPin) |-> !ctl.loadStat);

  // R2: set and clear never both requested
  assert_latch_excl_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.setWel && ctl.clrWel));
endmodule

// File: rtl/swg_regs.sv
module swg_regs
  import swg_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  swgCtlT            ctl,
  input  logic [STAT_W-1:0] wrData,
  input  logic [ADDR_W-1:0] wrAddr,
  output logic [STAT_W-1:0] statQ,
  output logic              welOut,
  output logic              lockOut,
  output logic              memWrOk
);
  localparam int TOP_HI = ADDR_W - 1;
  localparam int TOP_LO = ADDR_W - 2;

  logic [STAT_W-1:0] statNxt;
  protSelT           protSel;
  logic              inProt;

  always_comb begin
    statNxt = statQ;
    if (ctl.loadStat) begin
      statNxt          = wrData;
      statNxt[WEL_BIT] = statQ[WEL_BIT];   // latch is not loaded from data
    end
    if (ctl.clrWel)      statNxt[WEL_BIT] = 1'b0;
    else if (ctl.setWel) statNxt[WEL_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statQ <= '0;
    else       statQ <= statNxt;
  end

  assign welOut  = statQ[WEL_BIT];
  assign lockOut = statQ[LOCK_BIT];
  assign protSel = protSelT'(statQ[BP_HI:BP_LO]);

  // Range decode from the two top address bits.
  always_comb begin
    unique case (protSel)
      PROT_NONE:    inProt = 1'b0;
      PROT_QUARTER: inProt = wrAddr[TOP_HI] && wrAddr[TOP_LO];
      PROT_HALF:    inProt = wrAddr[TOP_HI];
      default:      inProt = 1'b1;
    endcase
  end

  assign memWrOk = welOut && !inProt;

  assert_set_latch_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.setWel |=> statQ[WEL_BIT]);

  assert_clr_latch_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clrWel |=> !statQ[WEL_BIT]);

  assert_refused_keep_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.loadStat && !ctl.setWel && !ctl.clrWel) |=> $stable(statQ));

  assert_wel_kept_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.loadStat && !ctl.setWel && !ctl.clrWel) |=> $stable(statQ[WEL_BIT]));

  assert_all_prot_R4: assert property (@(posedge clk) disable iff (!rstN)
    (statQ[BP_HI:BP_LO] == 2'b11) |-> !memWrOk);

  assert_no_latch_mem_R3: assert property (@(posedge clk) disable iff (!rstN)
    !statQ[WEL_BIT] |-> !memWrOk);
endmodule

// File: rtl/prot_status_unit.sv
module prot_status_unit
  import swg_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              setEnStb,
  input  logic              clrEnStb,
  input  logic              statWrStb,
  input  logic [7:0]        statWrData,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              wpPin,
  output logic [7:0]        statusByte,
  output logic              memWrOk,
  output logic              statWrOk
);
  swgCtlT ctl;
  logic   welQ;
  logic   lockQ;

  swg_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .setEnStb  (setEnStb),
    .clrEnStb  (clrEnStb),
    .statWrStb (statWrStb),
    .wpPin     (wpPin),
    .welIn     (welQ),
    .lockIn    (lockQ),
    .ctl       (ctl),
    .statWrOk  (statWrOk)
  );

  swg_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .wrData  (statWrData),
    .wrAddr  (wrAddr),
    .statQ   (statusByte),
    .welOut  (welQ),
    .lockOut (lockQ),
    .memWrOk (memWrOk)
  );
endmodule

// File: tb/prot_status_unit_tb.sv
module prot_status_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        setEnStb = 1'b0;
  logic        clrEnStb = 1'b0;
  logic        statWrStb = 1'b0;
  logic [7:0]  statWrData = 8'h00;
  logic [14:0] wrAddr = 15'h0;
  logic        wpPin = 1'b0;
  logic [7:0]  statusByte;
  logic        memWrOk;
  logic        statWrOk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  prot_status_unit u_dut (
    .clk(clk), .rstN(rstN), .setEnStb(setEnStb), .clrEnStb(clrEnStb),
    .statWrStb(statWrStb), .statWrData(statWrData), .wrAddr(wrAddr),
    .wpPin(wpPin), .statusByte(statusByte), .memWrOk(memWrOk), .statWrOk(statWrOk)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulseSet();
    @(negedge clk); setEnStb = 1'b1;
    @(negedge clk); setEnStb = 1'b0;
  endtask

  task automatic pulseClr();
    @(negedge clk); clrEnStb = 1'b1;
    @(negedge clk); clrEnStb = 1'b0;
  endtask

  task automatic statWrite(input logic [7:0] d, input logic pin);
    @(negedge clk); statWrStb = 1'b1; statWrData = d; wpPin = pin;
    @(negedge clk); statWrStb = 1'b0;
  endtask

  function automatic logic expPermit(input logic [1:0] bp, input logic [14:0] a);
    case (bp)
      2'b00:   return 1'b1;
      2'b01:   return a < 15'h6000;
      2'b10:   return a < 15'h4000;
      default: return 1'b0;
    endcase
  endfunction

  task automatic sweepAddr(input string req, input logic [1:0] bp);
    logic [14:0] pts [6] = '{15'h0000, 15'h3FFF, 15'h4000, 15'h5FFF, 15'h6000, 15'h7FFF};
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); wrAddr = pts[i]; #1;
      chk(req, {7'b0, memWrOk}, {7'b0, expPermit(bp, pts[i])});
    end
  endtask

  task automatic t_reset();
    #1;
    chk("R1 status", statusByte, 8'h00);
    chk("R1 statWrOk", {7'b0, statWrOk}, 8'h00);
    wrAddr = 15'h0000; #1;
    chk("R1 memWrOk lo", {7'b0, memWrOk}, 8'h00);
    wrAddr = 15'h7FFF; #1;
    chk("R1 memWrOk hi", {7'b0, memWrOk}, 8'h00);
  endtask

  task automatic t_noLatch();
    statWrite(8'h8C, 1'b1); #1;
    chk("R3 status kept", statusByte, 8'h00);
    chk("R3 statWrOk", {7'b0, statWrOk}, 8'h00);
    wrAddr = 15'h0010; #1;
    chk("R3 memWrOk", {7'b0, memWrOk}, 8'h00);
  endtask

  task automatic t_latch();
    pulseSet(); #1;
    chk("R2 set", statusByte, 8'h02);
    chk("R2 statWrOk", {7'b0, statWrOk}, 8'h01);
    pulseClr(); #1;
    chk("R2 clear", statusByte, 8'h00);
    pulseSet();
    @(negedge clk); setEnStb = 1'b1; clrEnStb = 1'b1;
    @(negedge clk); setEnStb = 1'b0; clrEnStb = 1'b0; #1;
    chk("R2 clear wins", statusByte, 8'h00);
  endtask

  task automatic t_load();
    pulseSet();
    statWrite(8'h7D, 1'b0); #1;
    chk("R5 load", statusByte, 8'h7F);
    chk("R8 latch kept", {7'b0, statusByte[1]}, 8'h01);
    statWrite(8'h71, 1'b0); #1;
    chk("R9 user bits", statusByte, 8'h73);
    sweepAddr("R9 user bits no effect", 2'b00);
  endtask

  task automatic t_blocks();
    for (int bp = 0; bp < 4; bp++) begin
      statWrite({4'b0, 2'(bp), 2'b0}, 1'b0); #1;
      chk("R4 bp load", statusByte, {4'b0, 2'(bp), 2'b10});
      sweepAddr("R4 range", 2'(bp));
    end
    statWrite(8'h00, 1'b0); #1;
    chk("R8 latch after sweeps", statusByte, 8'h02);
  endtask

  task automatic t_lock();
    statWrite(8'h80, 1'b1); #1;
    chk("R6 lock set", statusByte, 8'h82);
    @(negedge clk); wpPin = 1'b0; #1;
    chk("R6 statWrOk low pin", {7'b0, statWrOk}, 8'h00);
    statWrite(8'h0C, 1'b0); #1;
    chk("R7 refused keep", statusByte, 8'h82);
    @(negedge clk); wpPin = 1'b1; #1;
    chk("R6 statWrOk high pin", {7'b0, statWrOk}, 8'h01);
    statWrite(8'h0C, 1'b1); #1;
    chk("R6 unlock by pin", statusByte, 8'h0E);
  endtask

  task automatic t_pinSample();
    statWrite(8'h80, 1'b1); #1;
    @(negedge clk); statWrStb = 1'b1; statWrData = 8'h84; wpPin = 1'b1;
    @(negedge clk); statWrStb = 1'b0; wpPin = 1'b0; #1;
    chk("R10 pin high at strobe", statusByte, 8'h86);
    @(negedge clk); statWrStb = 1'b1; statWrData = 8'hF0; wpPin = 1'b0;
    @(negedge clk); statWrStb = 1'b0; wpPin = 1'b1; #1;
    chk("R10 pin low at strobe", statusByte, 8'h86);
    pulseClr(); #1;
    chk("R8 cleared by strobe", statusByte, 8'h84);
  endtask

  initial begin
    t_reset();
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    t_noLatch();
    t_latch();
    t_load();
    t_blocks();
    t_lock();
    t_pinSample();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule